// File: doc/BRIEF.md
# DRAM DMA Register Formatter

This block takes a single transfer request aimed at a sound card's on-card sample memory and converts it into the register writes that the card's DRAM DMA engine expects. A request holds a byte address in sample memory, a host buffer address, a byte count, a command byte, a host DMA channel number and an enhanced-mode flag. From these the block derives the engine's view of the sample address. That view depends on whether the channel moves 8-bit or 16-bit units and on the addressing mode. The block splits the result into a 16-bit low word and an 8-bit high byte. It also builds the final control byte, evens out the count where the transfer width requires it, and reports whether the host side reads or writes memory.

The block accepts a request through a valid/ready handshake and only while it is idle. It then writes its registers one per cycle on a simple write port. First it clears the control register and reads it back, which acknowledges any earlier transfer. Next come the low word and, in enhanced mode, the high byte. The control byte goes last. A one-cycle done pulse marks the end of the sequence. When a request names an address the engine cannot reach in its non-enhanced 16-bit form, the block emits a single error pulse and writes nothing.

Top module: `dram_dma_fmt`

## Requirements
- R1: For channel numbers 4 and above with enhanced mode on, the translated address is the 24-bit byte address shifted right by one.
- R2: For channel numbers 4 and above with enhanced mode off, a byte address with any of bits 4:0 set is rejected. `err` then pulses for one cycle, in the cycle after acceptance. No register access is made, and `in_ready` returns in the following cycle.
- R3: For channel numbers 4 and above with enhanced mode off, the translated address keeps bits 19:18 in place and takes byte-address bits 17:1 in bits 16:0. Bit 17 and bits 23:20 are zero.
- R4: For channel numbers 0 to 3 the translated address equals the byte address.
- R5: The control byte is the command with bit 0 (enable) set. Bit 2 (16-bit channel) is also set when the channel number is 4 or above. Command bit 1 means the host reads memory and bit 6 means 16-bit data.
- R6: When command bit 6 is set or the channel number is 4 or above, the count becomes (count+1) with bit 0 cleared, modulo 2^CNT_W. Otherwise the count is unchanged.
- R7: The low word is translated-address bits 19:4. The high byte carries translated-address bits 23:20 in bits 7:4 and bits 3:0 in bits 3:0.
- R8: Starting in the cycle after acceptance, one access is made per cycle in this order: a write of 0 to the control register, a read of the control register, a write of the low word, a write of the high byte (enhanced mode only), and a write of the control byte. The select codes are 0 for control, 1 for the low word and 2 for the high byte. Byte values sit in `reg_data` bits 7:0, with bits 15:8 at zero.
- R9: `done` pulses for exactly one cycle, in the cycle right after the control-byte write.
- R10: From the acceptance of a request that is not rejected, `host_rd` equals command bit 1, `host_buf` equals the buffer address and `host_count` equals the adjusted count. These values hold until the next such request is accepted, and a rejected request leaves them unchanged.
- R11: `in_ready` is high only while no sequence or pulse is in progress. A request presented while `in_ready` is low is not taken.
- R12: While `rst_n` is low and after its release, `in_ready` is high and `reg_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request taken at this edge if valid |
| in_dram_addr | input | 24 | Byte address in on-card sample memory |
| in_buf_addr | input | BUF_W | Host buffer address |
| in_count | input | CNT_W | Byte count |
| in_cmd | input | 8 | Command byte |
| in_chan | input | CHAN_W | Host DMA channel number |
| in_enh | input | 1 | Enhanced addressing mode |
| reg_valid | output | 1 | Register access this cycle |
| reg_rd | output | 1 | Access is a read-back |
| reg_sel | output | 2 | Register select: 0 control, 1 low word, 2 high byte |
| reg_data | output | 16 | Write data |
| host_buf | output | BUF_W | Host buffer address of last programmed request |
| host_count | output | CNT_W | Adjusted count of last programmed request |
| host_rd | output | 1 | Host side reads memory |
| done | output | 1 | Sequence finished |
| err | output | 1 | Request rejected |

## Verification
The closing pulse of one request, either `done` or `err`, can fall in the same cycle as the arrival of the next request. The bench provokes this by raising `in_valid` with the next request at the very cycle the pulse is seen. It judges the result by requiring that the request is taken only one cycle later, and that its access sequence then starts whole and in order. A sweep over every channel number, both modes, several command patterns, aligned and misaligned addresses and odd, even and maximum counts compares each register access, the pulses and the host outputs with values computed arithmetically.

// File: rtl/dmaf_pkg.sv
// Shared definitions for the DRAM DMA register formatter.
// Assumes a 24-bit on-card byte address and an 8-bit command byte.
package dmaf_pkg;
    localparam int DRAM_ADDR_W = 24;
    localparam int CMD_W       = 8;
    localparam int REG_DATA_W  = 16;

    // Command / control byte bit positions
    localparam int CB_ENABLE   = 0;
    localparam int CB_HOST_RD  = 1;
    localparam int CB_WIDE_CH  = 2;
    localparam int CB_DATA16   = 6;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2
    } reg_sel_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_WR,
        ST_ACK_RD,
        ST_WR_LOW,
        ST_WR_HIGH,
        ST_WR_CTRL,
        ST_DONE,
        ST_ERR
    } seq_state_e;
endpackage

// File: rtl/dmaf_addr_xlate.sv
// Address translation: maps a byte address to the DMA engine's address
// view and flags addresses the non-enhanced 16-bit form cannot reach.
// Purely combinational; assumes wide (16-bit) channels are those at or
// above WIDE_CHAN_MIN.
module dmaf_addr_xlate
    import dmaf_pkg::*;
#(
    parameter int CHAN_W        = 3,
    parameter int WIDE_CHAN_MIN = 4,
    parameter int ALIGN_BITS    = 5
) (
    input  logic [DRAM_ADDR_W-1:0] byte_addr,
    input  logic [CHAN_W-1:0]      chan,
    input  logic                   enh,
    output logic [DRAM_ADDR_W-1:0] xaddr,
    output logic [15:0]            low_word,
    output logic [7:0]             high_byte,
    output logic                   reject
);
    logic wide;

    // Channel width classification
    always_comb wide = (int'(chan) >= WIDE_CHAN_MIN);

    // Address mapping by channel width and mode
    always_comb begin
        reject = 1'b0;
        if (!wide) begin
            xaddr = byte_addr;
        end else if (enh) begin
            xaddr = {1'b0, byte_addr[DRAM_ADDR_W-1:1]};
        end else begin
            reject = |byte_addr[ALIGN_BITS-1:0];
            xaddr  = '0;
            xaddr[19:18] = byte_addr[19:18];
            xaddr[16:0]  = byte_addr[17:1];
        end
    end

    // Split into the two address registers
    always_comb begin
        low_word  = xaddr[19:4];
        high_byte = {xaddr[23:20], xaddr[3:0]};
    end
endmodule

// File: rtl/dmaf_cmd_fmt.sv
// Command formatting: builds the control byte, the host direction and
// the evened-out count. Purely combinational; the count wraps at its
// width when rounded up from the maximum odd value.
module dmaf_cmd_fmt
    import dmaf_pkg::*;
#(
    parameter int CHAN_W        = 3,
    parameter int CNT_W         = 16,
    parameter int WIDE_CHAN_MIN = 4
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [CHAN_W-1:0] chan,
    input  logic [CNT_W-1:0]  count,
    output logic [CMD_W-1:0]  ctrl_byte,
    output logic [CNT_W-1:0]  count_adj,
    output logic              host_rd
);
    logic wide;
    logic need_even;
    logic [CNT_W-1:0] bumped;

    // Channel width classification
    always_comb wide = (int'(chan) >= WIDE_CHAN_MIN);

    // Control byte assembly
    always_comb begin
        ctrl_byte = cmd;
        ctrl_byte[CB_ENABLE] = 1'b1;
        if (wide) ctrl_byte[CB_WIDE_CH] = 1'b1;
    end

    // Host direction from the command
    always_comb host_rd = cmd[CB_HOST_RD];

    // Even rounding; both triggers give the same single rounding
    always_comb begin
        need_even = cmd[CB_DATA16] | wide;
        bumped    = count + CNT_W'(1);
        count_adj = need_even ? {bumped[CNT_W-1:1], 1'b0} : count;
    end
endmodule

// File: rtl/dmaf_reg_seq.sv
// Register write sequencer: after a start it issues, one per cycle, the
// acknowledge write and read-back, the address words and the control
// byte, then a done pulse. A start with reject set yields a lone error
// pulse. Assumes start is only raised while ready is high.
module dmaf_reg_seq
    import dmaf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  reject,
    input  logic                  enh_q,
    input  logic [15:0]           low_q,
    input  logic [7:0]            high_q,
    input  logic [CMD_W-1:0]      ctrl_q,
    output logic                  ready,
    output logic                  reg_valid,
    output logic                  reg_rd,
    output logic [1:0]            reg_sel,
    output logic [REG_DATA_W-1:0] reg_data,
    output logic                  done,
    output logic                  err
);
    seq_state_e state, state_nx;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = reject ? ST_ERR : ST_ACK_WR;
            ST_ACK_WR:  state_nx = ST_ACK_RD;
            ST_ACK_RD:  state_nx = ST_WR_LOW;
            ST_WR_LOW:  state_nx = enh_q ? ST_WR_HIGH : ST_WR_CTRL;
            ST_WR_HIGH: state_nx = ST_WR_CTRL;
            ST_WR_CTRL: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            ST_ERR:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output decode per state
    always_comb begin
        ready     = (state == ST_IDLE);
        done      = (state == ST_DONE);
        err       = (state == ST_ERR);
        reg_valid = 1'b0;
        reg_rd    = 1'b0;
        reg_sel   = SEL_CTRL;
        reg_data  = '0;
        unique case (state)
            ST_ACK_WR: begin
                reg_valid = 1'b1;
            end
            ST_ACK_RD: begin
                reg_valid = 1'b1;
                reg_rd    = 1'b1;
            end
            ST_WR_LOW: begin
                reg_valid = 1'b1;
                reg_sel   = SEL_LOW;
                reg_data  = low_q;
            end
            ST_WR_HIGH: begin
                reg_valid = 1'b1;
                reg_sel   = SEL_HIGH;
                reg_data  = {8'h00, high_q};
            end
            ST_WR_CTRL: begin
                reg_valid = 1'b1;
                reg_data  = {8'h00, ctrl_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_dma_fmt.sv
// Top level of the DRAM DMA register formatter. Translates the request
// on acceptance, stores the derived values, and hands them to the
// sequencer. Host-side outputs change only on a request that is not
// rejected. Assumes in_* are stable while in_valid is high.
module dram_dma_fmt
    import dmaf_pkg::*;
#(
    parameter int BUF_W         = 24,
    parameter int CNT_W         = 16,
    parameter int CHAN_W        = 3,
    parameter int WIDE_CHAN_MIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DRAM_ADDR_W-1:0] in_dram_addr,
    input  logic [BUF_W-1:0]       in_buf_addr,
    input  logic [CNT_W-1:0]       in_count,
    input  logic [CMD_W-1:0]       in_cmd,
    input  logic [CHAN_W-1:0]      in_chan,
    input  logic                   in_enh,
    output logic                   reg_valid,
    output logic                   reg_rd,
    output logic [1:0]             reg_sel,
    output logic [REG_DATA_W-1:0]  reg_data,
    output logic [BUF_W-1:0]       host_buf,
    output logic [CNT_W-1:0]       host_count,
    output logic                   host_rd,
    output logic                   done,
    output logic                   err
);
    logic [DRAM_ADDR_W-1:0] xaddr;
    logic [15:0]            low_w, low_q;
    logic [7:0]             high_b, high_q;
    logic [CMD_W-1:0]       ctrl_b, ctrl_q;
    logic [CNT_W-1:0]       cnt_adj;
    logic                   dir_rd, reject, enh_q, start;

    dmaf_addr_xlate #(
        .CHAN_W(CHAN_W), .WIDE_CHAN_MIN(WIDE_CHAN_MIN), .ALIGN_BITS(5)
    ) u_xlate (
        .byte_addr(in_dram_addr), .chan(in_chan), .enh(in_enh),
        .xaddr(xaddr), .low_word(low_w), .high_byte(high_b), .reject(reject)
    );

    dmaf_cmd_fmt #(
        .CHAN_W(CHAN_W), .CNT_W(CNT_W), .WIDE_CHAN_MIN(WIDE_CHAN_MIN)
    ) u_cmd (
        .cmd(in_cmd), .chan(in_chan), .count(in_count),
        .ctrl_byte(ctrl_b), .count_adj(cnt_adj), .host_rd(dir_rd)
    );

    // Handshake acceptance
    always_comb start = in_valid & in_ready;

    // Capture of register values for the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            ctrl_q <= '0;
            enh_q  <= 1'b0;
        end else if (start) begin
            low_q  <= low_w;
            high_q <= high_b;
            ctrl_q <= ctrl_b;
            enh_q  <= in_enh;
        end
    end

    // Host-side values, updated only by programmed requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_buf   <= '0;
            host_count <= '0;
            host_rd    <= 1'b0;
        end else if (start && !reject) begin
            host_buf   <= in_buf_addr;
            host_count <= cnt_adj;
            host_rd    <= dir_rd;
        end
    end

    dmaf_reg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .reject(reject),
        .enh_q(enh_q), .low_q(low_q), .high_q(high_q), .ctrl_q(ctrl_q),
        .ready(in_ready), .reg_valid(reg_valid), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_data(reg_data), .done(done), .err(err)
    );
endmodule

// File: rtl/dmaf_checker.sv
// Protocol checker for dram_dma_fmt, attached by bind.
module dmaf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        reg_valid,
    input logic        reg_rd,
    input logic [1:0]  reg_sel,
    input logic [15:0] reg_data,
    input logic        done,
    input logic        err
);
    // R9
    done_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(reg_valid && !reg_rd && reg_sel == 2'd0 && reg_data != 16'h0));

    // R2
    err_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (in_ready && !reg_valid));

    // R8
    readback_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_rd) |-> $past(reg_valid && !reg_rd && reg_sel == 2'd0 && reg_data == 16'h0));

    // R11
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((reg_valid && !reg_rd && reg_data == 16'h0) || err));

    // R11
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ready, reg_valid, done, err}));

    // R8
    low_then_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_sel == 2'd1) |=> (reg_valid && !reg_rd && reg_sel != 2'd1));
endmodule

bind dram_dma_fmt dmaf_checker u_dmaf_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .reg_valid(reg_valid), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_data(reg_data), .done(done), .err(err)
);

// File: tb/tb_dram_dma_fmt.sv
module tb_dram_dma_fmt;
    localparam int BUF_W  = 24;
    localparam int CNT_W  = 16;
    localparam int CHAN_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [23:0] in_dram_addr = '0;
    logic [BUF_W-1:0] in_buf_addr = '0;
    logic [CNT_W-1:0] in_count = '0;
    logic [7:0] in_cmd = '0;
    logic [CHAN_W-1:0] in_chan = '0;
    logic in_enh = 1'b0;
    logic reg_valid, reg_rd, host_rd, done, err;
    logic [1:0] reg_sel;
    logic [15:0] reg_data;
    logic [BUF_W-1:0] host_buf;
    logic [CNT_W-1:0] host_count;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [BUF_W-1:0] exp_buf = '0;
    logic [CNT_W-1:0] exp_cnt = '0;
    logic exp_rd = 1'b0;

    always #2.5 clk = ~clk;

    dram_dma_fmt #(.BUF_W(BUF_W), .CNT_W(CNT_W), .CHAN_W(CHAN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dram_addr(in_dram_addr), .in_buf_addr(in_buf_addr),
        .in_count(in_count), .in_cmd(in_cmd), .in_chan(in_chan),
        .in_enh(in_enh), .reg_valid(reg_valid), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_data(reg_data), .host_buf(host_buf),
        .host_count(host_count), .host_rd(host_rd), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] xlate(input logic [23:0] a, input int ch, input logic enh);
        if (ch < 4) return a;                                     // R4
        if (enh) return a >> 1;                                   // R1
        return ((a & 24'h0C0000) | ((a & 24'h03FFFF) >> 1));      // R3
    endfunction

    // Sends one request (valid raised at once, possibly while busy) and
    // checks its whole response.
    task automatic run_req(input logic [23:0] a, input logic [BUF_W-1:0] b,
                           input logic [CNT_W-1:0] c, input logic [7:0] cmd,
                           input int ch, input logic enh);
        logic [23:0] x;
        logic [7:0] ctrl;
        logic [CNT_W-1:0] cnt;
        logic rej, rdy;
        x    = xlate(a, ch, enh);
        rej  = (ch >= 4) && !enh && (a[4:0] != 5'd0);
        ctrl = cmd | 8'h01 | ((ch >= 4) ? 8'h04 : 8'h00);         // R5
        cnt  = c;
        if (cmd[6] || ch >= 4) cnt = (c + 1'b1) & ~CNT_W'(1);     // R6
        in_dram_addr = a; in_buf_addr = b; in_count = c;
        in_cmd = cmd; in_chan = CHAN_W'(ch); in_enh = enh;
        in_valid = 1'b1;
        forever begin
            rdy = in_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
            check("R11 busy no start", {31'b0, reg_valid | done | err | in_ready}, 32'd1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (rej) begin
            check("R2 err pulse", {30'b0, err, reg_valid}, 32'b10);
            check("R10 host held", {host_rd, 7'b0, host_count}, {exp_rd, 7'b0, exp_cnt});
            check("R10 host buf held", 32'(host_buf), 32'(exp_buf));
            @(negedge clk);
            check("R2 ready after err", {30'b0, in_ready, err}, 32'b10);
            return;
        end
        exp_buf = b; exp_cnt = cnt; exp_rd = cmd[1];
        // R8 clear write
        check("R8 ack write", {reg_valid, reg_rd, reg_sel, 12'b0, reg_data}, {1'b1, 1'b0, 2'd0, 28'h0});
        @(negedge clk);
        check("R8 ack read", {reg_valid, reg_rd, reg_sel, 28'b0}, {1'b1, 1'b1, 2'd0, 28'h0});
        @(negedge clk);
        // R7 low word
        check("R7 low word", {reg_valid, reg_rd, reg_sel, 12'b0, reg_data}, {1'b1, 1'b0, 2'd1, 12'b0, x[19:4]});
        if (enh) begin
            @(negedge clk);
            check("R7 high byte", {reg_valid, reg_rd, reg_sel, 12'b0, reg_data},
                  {1'b1, 1'b0, 2'd2, 20'b0, x[23:20], x[3:0]});
        end
        @(negedge clk);
        check("R5 ctrl write", {reg_valid, reg_rd, reg_sel, 12'b0, reg_data}, {1'b1, 1'b0, 2'd0, 20'b0, ctrl});
        check("R9 no early done", {31'b0, done}, 32'd0);
        @(negedge clk);
        check("R9 done pulse", {29'b0, done, reg_valid, in_ready}, 32'b100);
        check("R10 host dir/count", {host_rd, 7'b0, host_count}, {exp_rd, 7'b0, exp_cnt});
        check("R6 count", 32'(host_count), 32'(cnt));
        check("R10 host buf", 32'(host_buf), 32'(exp_buf));
    endtask

    initial begin
        logic [23:0] addrs [6];
        logic [7:0]  cmds  [5];
        logic [15:0] cnts  [4];
        addrs = '{24'h000000, 24'h000021, 24'h0FFFE0, 24'hABCDE0, 24'h3C0040, 24'h12345F};
        cmds  = '{8'h00, 8'h02, 8'h40, 8'h42, 8'h20};
        cnts  = '{16'h0000, 16'h0003, 16'h1234, 16'hFFFF};
        repeat (3) begin
            @(negedge clk);
            // R12 state during reset
            check("R12 in reset", {28'b0, in_ready, reg_valid, done, err}, 32'b1000);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {28'b0, in_ready, reg_valid, done, err}, 32'b1000);
        check("R12 host reset", {host_rd, 7'b0, host_count}, 32'd0);
        for (int ch = 0; ch < 8; ch++)
            for (int e = 0; e < 2; e++)
                for (int ci = 0; ci < 5; ci++)
                    for (int ai = 0; ai < 6; ai++)
                        for (int ni = 0; ni < 4; ni++)
                            run_req(addrs[ai], BUF_W'(ch * 4099 + ai * 77 + ni), cnts[ni],
                                    cmds[ci], ch, e[0]);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule